// File: doc/BRIEF.md
# Store Write-Policy Controller

This block sits beside a set-associative data cache and handles every store the cache receives. A per-access attribute travelling with each store chooses the policy. When the attribute selects write-through, the store always goes out to external memory, and the cached copy is also updated if the lookup hit. When the attribute selects write-back, a hit changes only the cached copy and marks that line as modified. A store that misses never allocates a line. It is forwarded to external memory unchanged, whatever the attribute says.

The controller keeps one modified (dirty) bit per cache line. When the replacement logic or a cache-clean sequence presents a line on the eviction port, the controller writes it out only if its dirty bit is set, and then clears that bit. Tag lookup, line fill and victim selection happen outside the block. Their results arrive as the hit flag, the way number and the eviction request. All external writes leave through a single registered slot with a valid/ready handshake.

Top module: `store_policy_ctrl`

## Requirements
- R1: The policy is chosen per store from `st_wt` (1 = write-through, 0 = write-back). Consecutive stores to the same line may use different policies.
- R2: An accepted write-through hit drives `cache_we` high in the same cycle. In that cycle `cache_set` equals address bits [3:2], and `cache_way`, `cache_be` and `cache_data` equal the request fields. In the next cycle `mem_valid` rises, carrying the store's address, byte enables and data.
- R3: A write-through store never sets a dirty bit. A later eviction of a line written only that way produces no external write.
- R4: An accepted write-back hit updates the cache as in R2 and produces no external write (`mem_valid` stays low in the next cycle).
- R5: A write-back hit sets the dirty bit of line (set, way). Eviction or clean of a dirty line raises `mem_valid` in the next cycle, carrying `ev_addr`, `ev_data` and all byte enables set, and clears the bit. A second eviction of the same line then produces no write.
- R6: Eviction or clean of a line whose dirty bit is clear produces no external write.
- R7: An accepted store miss leaves `cache_we` low and is forwarded to external memory in the next cycle, under either attribute.
- R8: While `mem_valid` is high and `mem_ready` is low, the payload on the `mem_*` outputs holds steady, and `st_ready` and `ev_ready` are low. A store held pending during this stall is accepted once `mem_ready` returns.
- R9: When `ev_valid` is high, `st_ready` is low. The eviction is served first.
- R10: Reset clears every dirty bit and drops `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store byte address |
| st_be | input | DATA_W/8 | Store byte enables |
| st_data | input | DATA_W | Store data |
| st_wt | input | 1 | Policy attribute: 1 write-through, 0 write-back |
| st_hit | input | 1 | Lookup result: line present |
| st_way | input | log2(WAYS) | Way that hit |
| cache_we | output | 1 | Cache line update strobe |
| cache_set | output | log2(SETS) | Set to update |
| cache_way | output | log2(WAYS) | Way to update |
| cache_be | output | DATA_W/8 | Bytes to update |
| cache_data | output | DATA_W | Update data |
| ev_valid | input | 1 | Eviction or clean request |
| ev_ready | output | 1 | Eviction accepted this cycle when high with ev_valid |
| ev_set | input | log2(SETS) | Victim set |
| ev_way | input | log2(WAYS) | Victim way |
| ev_addr | input | ADDR_W | Victim line address |
| ev_data | input | DATA_W | Victim line contents |
| mem_valid | output | 1 | External write present |
| mem_ready | input | 1 | External memory takes the write |
| mem_addr | output | ADDR_W | External write address |
| mem_be | output | DATA_W/8 | External write byte enables |
| mem_data | output | DATA_W | External write data |

## Verification
The assertions assume that `st_hit` and `st_way` are stable companions of `st_valid`. They also assume that the eviction port names a real line whose data the cache supplies, and that the outside logic keeps a request valid until it is accepted. The bench drives each request from a falling edge and holds it until the rising edge that accepts it. It keeps `mem_ready` high except in the stall test, so every external write drains in one cycle. It never sends an eviction for a line and a store to that same line in one cycle, because the eviction port's precedence already separates them.

// File: rtl/store_policy_ctrl.sv
module store_policy_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int BE_W   = DATA_W / 8,
  parameter int SET_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [BE_W-1:0]   st_be,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_wt,
  input  logic              st_hit,
  input  logic [WAY_W-1:0]  st_way,
  output logic              cache_we,
  output logic [SET_W-1:0]  cache_set,
  output logic [WAY_W-1:0]  cache_way,
  output logic [BE_W-1:0]   cache_be,
  output logic [DATA_W-1:0] cache_data,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [SET_W-1:0]  ev_set,
  input  logic [WAY_W-1:0]  ev_way,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [DATA_W-1:0] mem_data
);
  localparam int LINES = SETS * WAYS;
  localparam int OFF_W = $clog2(BE_W);
  localparam int IDX_W = SET_W + WAY_W;

  logic [LINES-1:0] dirty;
  logic             busy, st_fire, ev_fire, wb_hit;
  logic [IDX_W-1:0] st_idx, ev_idx;

  assign busy     = mem_valid & ~mem_ready;
  assign ev_ready = ~busy;
  assign st_ready = ~busy & ~ev_valid;
  assign st_fire  = st_valid & st_ready;
  assign ev_fire  = ev_valid & ev_ready;
  assign wb_hit   = st_hit & ~st_wt;

  assign cache_set  = st_addr[OFF_W +: SET_W];
  assign cache_way  = st_way;
  assign cache_be   = st_be;
  assign cache_data = st_data;
  assign cache_we   = st_fire & st_hit;

  assign st_idx = {cache_set, st_way};
  assign ev_idx = {ev_set, ev_way};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty     <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_data  <= '0;
    end else begin
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      if (ev_fire) begin
        dirty[ev_idx] <= 1'b0;
        if (dirty[ev_idx]) begin
          mem_valid <= 1'b1;
          mem_addr  <= ev_addr;
          mem_be    <= '1;
          mem_data  <= ev_data;
        end
      end else if (st_fire) begin
        if (wb_hit) begin
          dirty[st_idx] <= 1'b1;
        end else begin
          mem_valid <= 1'b1;
          mem_addr  <= st_addr;
          mem_be    <= st_be;
          mem_data  <= st_data;
        end
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_data));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !st_ready && !ev_ready);

  p_wb_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_hit && !st_wt |=> !mem_valid);

  p_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && (st_wt || !st_hit) |=>
      mem_valid && mem_addr == $past(st_addr) && mem_data == $past(st_data) && mem_be == $past(st_be));

  p_evict_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !st_ready);

  p_wt_no_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_wt |=> dirty == $past(dirty));

  p_clean_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !dirty[ev_idx] |=> !mem_valid);

endmodule

// File: tb/test_store_policy_ctrl.sv
`timescale 1ns/1ps
module test_store_policy_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_wt = 1'b0, st_hit = 1'b0;
  logic        st_ready;
  logic [15:0] st_addr = '0;
  logic [3:0]  st_be = '0;
  logic [31:0] st_data = '0;
  logic [1:0]  st_way = '0;
  logic        cache_we;
  logic [1:0]  cache_set, cache_way;
  logic [3:0]  cache_be;
  logic [31:0] cache_data;
  logic        ev_valid = 1'b0, ev_ready;
  logic [1:0]  ev_set = '0, ev_way = '0;
  logic [15:0] ev_addr = '0;
  logic [31:0] ev_data = '0;
  logic        mem_valid, mem_ready = 1'b1;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  store_policy_ctrl i_store_policy_ctrl (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wt;
    logic        hit;
    logic [1:0]  way;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } vec_t;

  // Set index = addr[3:2]; write-back hits are silent, everything else goes out.
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b1, 2'd1, 16'h0004, 4'hF, 32'hA1A1_0001},
    '{1'b1, 1'b1, 2'd2, 16'h0008, 4'h3, 32'hB2B2_0002},
    '{1'b0, 1'b0, 2'd0, 16'h0010, 4'hC, 32'hC3C3_0003},
    '{1'b1, 1'b0, 2'd3, 16'h0024, 4'h1, 32'hD4D4_0004},
    '{1'b0, 1'b1, 2'd3, 16'h000C, 4'h6, 32'hE5E5_0005},
    '{1'b1, 1'b1, 2'd1, 16'h0004, 4'h8, 32'hF6F6_0006},
    '{1'b0, 1'b1, 2'd0, 16'h0000, 4'hF, 32'h0707_0007}
  };

  task automatic store(input vec_t v, input string tag);
    bit exp_mem;
    exp_mem = v.wt | ~v.hit;
    @(negedge clk);
    st_valid = 1; st_wt = v.wt; st_hit = v.hit; st_way = v.way;
    st_addr = v.addr; st_be = v.be; st_data = v.data;
    #0.5;
    check(cache_we == v.hit, {tag, " cache_we"}, 64'(cache_we), 64'(v.hit));
    if (v.hit)
      check(cache_set == v.addr[3:2] && cache_way == v.way && cache_be == v.be && cache_data == v.data,
            {tag, " cache fields"}, {cache_set, cache_way, cache_be, cache_data}, {v.addr[3:2], v.way, v.be, v.data});
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
    check(mem_valid == exp_mem, {tag, " mem_valid"}, 64'(mem_valid), 64'(exp_mem));
    if (exp_mem)
      check(mem_addr == v.addr && mem_be == v.be && mem_data == v.data, {tag, " mem payload"},
            {mem_addr, mem_be, mem_data}, {v.addr, v.be, v.data});
  endtask

  task automatic evict(input logic [1:0] s, input logic [1:0] w, input logic [31:0] d,
                       input bit exp_wr, input string tag);
    @(negedge clk);
    ev_valid = 1; ev_set = s; ev_way = w; ev_addr = {12'h100, s, 2'b00}; ev_data = d;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0;
    check(mem_valid == exp_wr, {tag, " evict write"}, 64'(mem_valid), 64'(exp_wr));
    if (exp_wr)
      check(mem_addr == {12'h100, s, 2'b00} && mem_be == 4'hF && mem_data == d, {tag, " evict payload"},
            {mem_addr, mem_be, mem_data}, {12'h100, s, 2'b00, 4'hF, d});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_valid == 0, "R10 reset mem_valid", 64'(mem_valid), 64'(0));
    rst_n = 1;

    foreach (VECS[i]) begin
      string tag;
      tag = !VECS[i].hit ? "R7 miss" : (VECS[i].wt ? "R1/R2 wt hit" : "R1/R4 wb hit");
      store(VECS[i], tag);
    end

    evict(2'd1, 2'd1, 32'h1111_0001, 1, "R5 dirty set1");
    evict(2'd2, 2'd2, 32'h2222_0002, 0, "R3 wt line");
    evict(2'd3, 2'd3, 32'h3333_0003, 1, "R5 dirty set3");
    evict(2'd0, 2'd0, 32'h4444_0004, 1, "R5 dirty set0");
    evict(2'd0, 2'd1, 32'h5555_0005, 0, "R6 never written");
    evict(2'd1, 2'd1, 32'h6666_0006, 0, "R5 cleared after writeback");

    // R8 stall
    @(negedge clk);
    mem_ready = 0;
    st_valid = 1; st_wt = 1; st_hit = 1; st_way = 2; st_addr = 16'h0030; st_be = 4'h5; st_data = 32'h8888_0001;
    @(posedge clk);
    @(negedge clk);
    st_data = 32'h8888_0002; st_addr = 16'h0034;
    #0.5;
    check(st_ready == 0 && ev_ready == 0, "R8 ready low in stall", {st_ready, ev_ready}, 2'b00);
    @(posedge clk);
    @(negedge clk);
    check(mem_valid == 1 && mem_data == 32'h8888_0001 && mem_addr == 16'h0030, "R8 payload held",
          {mem_valid, mem_addr, mem_data}, {1'b1, 16'h0030, 32'h8888_0001});
    mem_ready = 1;
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
    check(mem_valid == 1 && mem_data == 32'h8888_0002 && mem_addr == 16'h0034, "R8 pending store taken",
          {mem_valid, mem_addr, mem_data}, {1'b1, 16'h0034, 32'h8888_0002});

    // R9 eviction before store
    @(negedge clk);
    ev_valid = 1; ev_set = 0; ev_way = 2; ev_addr = 16'h1000; ev_data = 32'h9;
    st_valid = 1; st_wt = 1; st_hit = 0; st_addr = 16'h0040; st_be = 4'hF; st_data = 32'h9999_0001;
    #0.5;
    check(st_ready == 0 && ev_ready == 1, "R9 eviction first", {st_ready, ev_ready}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0;
    check(mem_valid == 0, "R9 store held back", 64'(mem_valid), 64'(0));
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
    check(mem_valid == 1 && mem_data == 32'h9999_0001, "R9 store after eviction",
          {mem_valid, mem_data}, {1'b1, 32'h9999_0001});

    // R10 reset clears dirty
    store('{1'b0, 1'b1, 2'd0, 16'h0008, 4'hF, 32'hABCD_0001}, "R4 wb hit before reset");
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(mem_valid == 0, "R10 mem_valid in reset", 64'(mem_valid), 64'(0));
    rst_n = 1;
    evict(2'd2, 2'd0, 32'hDEAD_0001, 0, "R10 dirty cleared by reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule